// File: doc/BRIEF.md
# Post-Update Indexed Store Unit

This unit carries out indexed stores that also advance their base register. For each operation it takes a size code, the index of the base register, and the contents of the data, base and index registers as read from the register file. The store goes out on a 64-bit big-endian memory write port with byte enables. The store address is the base register value as it was read, before any update. The sum of base and index is returned as a writeback request for the base register. Nothing else in the machine state changes.

A small state machine sequences each operation. The unit accepts an operation in state `IDLE` and registers the address, the lane-steered data, the byte enables and the updated base.

- If the operation is clean, `IDLE` goes to `STORE` (the accept-clean transition). `STORE` holds the memory request until the memory takes it. The writeback is raised in the cycle the memory accepts, and `STORE` then returns to `IDLE` (the mem-accept transition).
- If the operation names register 0 as its base, or the base address is not aligned for the size, `IDLE` goes to `FAULT` (the accept-fault transition). `FAULT` pulses the matching flag for one cycle, issues no memory write and no writeback, and always returns to `IDLE` (the fault-done transition).

The rest of the pipeline uses the flags to raise its own exception.

Top module: `psu_store_unit`

## Requirements
- R1: The memory address of a store equals the base register value presented at acceptance, not the updated sum.
- R2: `wb_valid` is high exactly in the cycles where `mem_valid` and `mem_ready` are both high. In those cycles `wb_idx` equals the accepted base index and `wb_data` equals base + index modulo 2^64.
- R3: Size code 0 stores 1 byte, 1 stores 2 bytes, 2 stores 4 bytes and 3 stores 8 bytes. `mem_be[i]` enables `mem_wdata[8i+7:8i]`, and address offset o (the low three address bits) maps to lane 7-o. A store of n bytes at offset o enables exactly lanes 7-o down to 8-o-n.
- R4: The stored bytes are the least significant n bytes of the data register, with the most significant of them at offset o. All disabled lanes carry zero.
- R5: A base index of 0 raises `illegal_form` for exactly the one cycle after acceptance. No memory write and no writeback occur, and this check takes priority over misalignment.
- R6: A nonzero base index with an address not a multiple of n raises `misaligned` for exactly the one cycle after acceptance, with no memory write and no writeback.
- R7: When the data and base registers are the same register, the stored bytes come from the value read at acceptance, not from the updated sum.
- R8: `op_ready` is high only in `IDLE`. `mem_valid` rises in the cycle after acceptance, and address, data and enables hold steady until `mem_ready`. After the accepting cycle the unit is idle again.
- R9: After reset the unit is in `IDLE`, with `op_ready` high and `mem_valid`, `wb_valid`, `illegal_form` and `misaligned` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit can accept an operation |
| op_size | input | 2 | Size code: 0 byte, 1 halfword, 2 word, 3 doubleword |
| ra_idx | input | 5 | Base register index |
| rs_val | input | 64 | Data register contents |
| ra_val | input | 64 | Base register contents |
| rb_val | input | 64 | Index register contents |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory takes the request |
| mem_addr | output | 64 | Store address |
| mem_be | output | 8 | Byte lane enables |
| mem_wdata | output | 64 | Lane-steered store data |
| wb_valid | output | 1 | Base register writeback strobe |
| wb_idx | output | 5 | Writeback register index |
| wb_data | output | 64 | Updated base value |
| illegal_form | output | 1 | Base index zero fault pulse |
| misaligned | output | 1 | Unaligned address fault pulse |

## Verification
The bench sweeps every size against every one of the eight address offsets, with two data patterns and varying memory stall lengths. It computes enables and data by shift arithmetic, so a design that mirrored the lane order would put bytes in the wrong lanes, and one that stored the sum as the address would miss every address check. Base index 0 is tried at every size, including unaligned offsets, so a design that let the misalignment test win would raise the wrong flag. A design that wrote anything back on a fault would show a stray writeback strobe. A carry-out case exposes a truncated sum. A data-equals-base case exposes forwarding of the updated value into the store data. Held-off `mem_ready` exposes a writeback raised before the memory accepts, and a request that drifts while it is stalled.

// File: rtl/psu_pkg.sv
package psu_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } psu_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STORE = 2'd1,
        ST_FAULT = 2'd2
    } psu_state_e;

    // number of bytes moved by a size code
    function automatic int size_bytes(input psu_size_e sz);
        return 1 << int'(sz);
    endfunction

endpackage

// File: rtl/psu_lane_steer.sv
module psu_lane_steer
    import psu_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int LANES = XLEN / 8,
    parameter int OFF_W = $clog2(LANES)
) (
    input  psu_size_e        size,
    input  logic [OFF_W-1:0] offset,
    input  logic [XLEN-1:0]  rs_val,
    output logic [LANES-1:0] be,
    output logic [XLEN-1:0]  wdata
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // big-endian: lane i holds address offset LANES-1-i
        localparam int POS = LANES - 1 - i;
        logic       hit;
        logic [7:0] lane_byte;

        always_comb begin
            int o;
            int n;
            int src;
            o         = int'(offset);
            n         = size_bytes(size);
            src       = 0;
            hit       = 1'b0;
            lane_byte = 8'h00;
            if (POS >= o && POS < o + n) begin
                hit       = 1'b1;
                src       = n - 1 - (POS - o);
                lane_byte = rs_val[8*src +: 8];
            end
        end

        assign be[i]           = hit;
        assign wdata[8*i +: 8] = lane_byte;
    end

endmodule

// File: rtl/psu_fault_check.sv
module psu_fault_check
    import psu_pkg::*;
#(
    parameter int IDX_W = 5,
    parameter int OFF_W = 3
) (
    input  psu_size_e        size,
    input  logic [IDX_W-1:0] base_idx,
    input  logic [OFF_W-1:0] addr_low,
    output logic             bad_form,
    output logic             bad_align
);

    always_comb begin
        int n;
        n         = size_bytes(size);
        bad_form  = (base_idx == '0);
        // form fault wins: alignment only reported for a legal encoding
        bad_align = !bad_form && ((int'(addr_low) & (n - 1)) != 0);
    end

endmodule

// File: rtl/psu_ctrl.sv
module psu_ctrl
    import psu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic op_valid,
    input  logic mem_ready,
    input  logic bad_form,
    input  logic bad_align,
    output logic op_ready,
    output logic load,
    output logic mem_valid,
    output logic wb_valid,
    output logic illegal_form,
    output logic misaligned
);

    psu_state_e state_q, state_d;
    logic       form_q, align_q;
    logic       accept;

    assign accept = op_valid && (state_q == ST_IDLE);
    assign load   = accept;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            form_q  <= 1'b0;
            align_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                form_q  <= bad_form;
                align_q <= bad_align;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = (bad_form || bad_align) ? ST_FAULT : ST_STORE;
                end
            end
            ST_STORE: begin
                if (mem_ready) state_d = ST_IDLE;
            end
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        op_ready     = 1'b0;
        mem_valid    = 1'b0;
        wb_valid     = 1'b0;
        illegal_form = 1'b0;
        misaligned   = 1'b0;
        unique case (state_q)
            ST_IDLE:  op_ready = 1'b1;
            ST_STORE: begin
                mem_valid = 1'b1;
                wb_valid  = mem_ready;
            end
            ST_FAULT: begin
                illegal_form = form_q;
                misaligned   = align_q;
            end
            default: op_ready = 1'b0;
        endcase
    end

endmodule

// File: rtl/psu_store_unit.sv
module psu_store_unit
    import psu_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic [1:0]        op_size,
    input  logic [IDX_W-1:0]  ra_idx,
    input  logic [XLEN-1:0]   rs_val,
    input  logic [XLEN-1:0]   ra_val,
    input  logic [XLEN-1:0]   rb_val,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN/8-1:0] mem_be,
    output logic [XLEN-1:0]   mem_wdata,
    output logic              wb_valid,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [XLEN-1:0]   wb_data,
    output logic              illegal_form,
    output logic              misaligned
);

    localparam int LANES = XLEN / 8;
    localparam int OFF_W = $clog2(LANES);

    psu_size_e        size;
    logic [LANES-1:0] be_c;
    logic [XLEN-1:0]  wdata_c;
    logic             bad_form, bad_align, load;

    logic [XLEN-1:0]  addr_q, wdata_q, ea_q;
    logic [LANES-1:0] be_q;
    logic [IDX_W-1:0] idx_q;

    assign size = psu_size_e'(op_size);

    psu_lane_steer #(.XLEN(XLEN), .LANES(LANES), .OFF_W(OFF_W)) u_steer (
        .size   (size),
        .offset (ra_val[OFF_W-1:0]),
        .rs_val (rs_val),
        .be     (be_c),
        .wdata  (wdata_c)
    );

    psu_fault_check #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_fault (
        .size      (size),
        .base_idx  (ra_idx),
        .addr_low  (ra_val[OFF_W-1:0]),
        .bad_form  (bad_form),
        .bad_align (bad_align)
    );

    psu_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_valid     (op_valid),
        .mem_ready    (mem_ready),
        .bad_form     (bad_form),
        .bad_align    (bad_align),
        .op_ready     (op_ready),
        .load         (load),
        .mem_valid    (mem_valid),
        .wb_valid     (wb_valid),
        .illegal_form (illegal_form),
        .misaligned   (misaligned)
    );

    // operands captured at issue: the store uses pre-update values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            ea_q    <= '0;
            be_q    <= '0;
            idx_q   <= '0;
        end else if (load) begin
            addr_q  <= ra_val;
            wdata_q <= wdata_c;
            ea_q    <= ra_val + rb_val;
            be_q    <= be_c;
            idx_q   <= ra_idx;
        end
    end

    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;
    assign mem_be    = be_q;
    assign wb_idx    = idx_q;
    assign wb_data   = ea_q;

endmodule

// File: rtl/psu_store_checker.sv
module psu_store_checker #(
    parameter int XLEN  = 64,
    parameter int IDX_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic              op_ready,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [XLEN-1:0]   mem_addr,
    input logic [XLEN/8-1:0] mem_be,
    input logic [XLEN-1:0]   mem_wdata,
    input logic              wb_valid,
    input logic [IDX_W-1:0]  wb_idx,
    input logic              illegal_form,
    input logic              misaligned
);

    p_wb_needs_mem_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (mem_valid && mem_ready));

    p_mem_gives_wb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready) |-> wb_valid);

    p_be_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                       $countones(mem_be) == 4 || $countones(mem_be) == 8));

    p_wb_not_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_idx != '0));

    p_fault_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_form || misaligned) |-> (!mem_valid && !wb_valid && !(illegal_form && misaligned)));

    p_fault_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_form || misaligned) |=> (!illegal_form && !misaligned && op_ready));

    p_issue_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready) |=> (mem_valid || illegal_form || misaligned));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                        $stable(mem_be) && $stable(mem_wdata)));

    p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid || illegal_form || misaligned) |-> !op_ready);

endmodule

bind psu_store_unit psu_store_checker #(.XLEN(XLEN), .IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_valid     (op_valid),
    .op_ready     (op_ready),
    .mem_valid    (mem_valid),
    .mem_ready    (mem_ready),
    .mem_addr     (mem_addr),
    .mem_be       (mem_be),
    .mem_wdata    (mem_wdata),
    .wb_valid     (wb_valid),
    .wb_idx       (wb_idx),
    .illegal_form (illegal_form),
    .misaligned   (misaligned)
);

// File: tb/psu_store_unit_bench.sv
module psu_store_unit_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_ready;
    logic [1:0]  op_size = 2'd0;
    logic [4:0]  ra_idx = 5'd0;
    logic [63:0] rs_val = '0, ra_val = '0, rb_val = '0;
    logic        mem_valid;
    logic        mem_ready = 1'b0;
    logic [63:0] mem_addr, mem_wdata, wb_data;
    logic [7:0]  mem_be;
    logic        wb_valid;
    logic [4:0]  wb_idx;
    logic        illegal_form, misaligned;

    int  tests = 0;
    int  fails = 0;
    bit  done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    psu_store_unit u_psu_store_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
        .op_size(op_size), .ra_idx(ra_idx), .rs_val(rs_val), .ra_val(ra_val),
        .rb_val(rb_val), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data),
        .illegal_form(illegal_form), .misaligned(misaligned)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] sz, input logic [4:0] ai,
                          input logic [63:0] sv, input logic [63:0] av,
                          input logic [63:0] bv, input int stall,
                          input string dreq);
        int n, off, sh;
        logic [63:0] mask, exp_d;
        logic [7:0]  exp_be;
        n   = 1 << sz;
        off = int'(av[2:0]);
        @(negedge clk);
        op_valid = 1'b1; op_size = sz; ra_idx = ai;
        rs_val = sv; ra_val = av; rb_val = bv;
        chk("R8", "op_ready before issue", 64'(op_ready), 64'd1);
        @(negedge clk);
        op_valid = 1'b0;
        rs_val = '1; ra_val = '1; rb_val = '1;
        if (ai == 5'd0) begin
            chk("R5", "illegal_form", 64'(illegal_form), 64'd1);
            chk("R5", "misaligned on bad form", 64'(misaligned), 64'd0);
            chk("R5", "mem_valid on bad form", 64'(mem_valid), 64'd0);
            chk("R5", "wb_valid on bad form", 64'(wb_valid), 64'd0);
            @(negedge clk);
            chk("R5", "illegal_form one cycle", 64'(illegal_form), 64'd0);
            chk("R8", "idle after fault", 64'(op_ready), 64'd1);
        end else if ((off % n) != 0) begin
            chk("R6", "misaligned", 64'(misaligned), 64'd1);
            chk("R6", "illegal_form on misalign", 64'(illegal_form), 64'd0);
            chk("R6", "mem_valid on misalign", 64'(mem_valid), 64'd0);
            chk("R6", "wb_valid on misalign", 64'(wb_valid), 64'd0);
            @(negedge clk);
            chk("R6", "misaligned one cycle", 64'(misaligned), 64'd0);
            chk("R8", "idle after fault", 64'(op_ready), 64'd1);
        end else begin
            sh     = 8 - off - n;
            mask   = (n == 8) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8*n)) - 64'd1);
            exp_d  = (sv & mask) << (8*sh);
            exp_be = 8'(((1 << n) - 1) << sh);
            chk("R8", "mem_valid after issue", 64'(mem_valid), 64'd1);
            chk("R8", "op_ready while busy", 64'(op_ready), 64'd0);
            chk("R1", "mem_addr", mem_addr, av);
            chk("R3", "mem_be", 64'(mem_be), 64'(exp_be));
            chk(dreq, "mem_wdata", mem_wdata, exp_d);
            for (int k = 0; k < stall; k++) begin
                chk("R2", "wb_valid while stalled", 64'(wb_valid), 64'd0);
                @(negedge clk);
                chk("R8", "held mem_valid", 64'(mem_valid), 64'd1);
                chk("R8", "held mem_addr", mem_addr, av);
                chk("R8", "held mem_wdata", mem_wdata, exp_d);
            end
            mem_ready = 1'b1;
            #1;
            chk("R2", "wb_valid on accept", 64'(wb_valid), 64'd1);
            chk("R2", "wb_idx", 64'(wb_idx), 64'(ai));
            chk("R2", "wb_data", wb_data, av + bv);
            @(negedge clk);
            mem_ready = 1'b0;
            #1;
            chk("R8", "mem_valid after accept", 64'(mem_valid), 64'd0);
            chk("R8", "op_ready after accept", 64'(op_ready), 64'd1);
            chk("R2", "wb_valid after accept", 64'(wb_valid), 64'd0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R9", "op_ready after reset", 64'(op_ready), 64'd1);
        chk("R9", "mem_valid after reset", 64'(mem_valid), 64'd0);
        chk("R9", "wb_valid after reset", 64'(wb_valid), 64'd0);
        chk("R9", "flags after reset", 64'({illegal_form, misaligned}), 64'd0);

        // full sweep: size x offset x pattern (R3, R4, R6 coverage)
        for (int s = 0; s < 4; s++) begin
            for (int o = 0; o < 8; o++) begin
                for (int p = 0; p < 2; p++) begin
                    logic [63:0] sv, av, bv;
                    sv = p ? 64'hF0E1_D2C3_B4A5_9687 : 64'h0123_4567_89AB_CDEF;
                    av = 64'h0000_1000_2000_3000 | 64'(o);
                    bv = p ? 64'hFFFF_FFFF_FFFF_FFF8 : 64'(64'h100 * (s + 1) + o);
                    run_op(2'(s), 5'(3 + s + p), sv, av, bv, (o + p) % 3, "R4");
                end
            end
        end

        // base index zero at every size, aligned and not: R5 priority
        for (int s = 0; s < 4; s++) begin
            run_op(2'(s), 5'd0, 64'h1111_2222_3333_4444, 64'h8000_0000_0000_0000, 64'd8, 0, "R5");
            run_op(2'(s), 5'd0, 64'h1111_2222_3333_4444, 64'h8000_0000_0000_0005, 64'd8, 0, "R5");
        end

        // data register equals base register: pre-update value stored (R7)
        run_op(2'd3, 5'd9, 64'h0000_0000_0000_4000, 64'h0000_0000_0000_4000, 64'd64, 1, "R7");
        run_op(2'd2, 5'd9, 64'h0000_7777_0000_4004, 64'h0000_7777_0000_4004, 64'd4, 2, "R7");
        // carry across the full width of the sum (R2)
        run_op(2'd0, 5'd31, 64'hAB, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 0, "R4");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R8: watchdog expired actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule